// File: doc/BRIEF.md
# Paged Memory Access Firewall

This block sits in front of a small on-chip memory that is split into 4 KiB pages and decides, in the same cycle as each request, whether the access may proceed. Every page carries its own security attribute, default privilege attribute and compartment filter setting. Per-compartment read, write and privilege bitmaps, with one bit per page, refine the decision when filtering is enabled for a page. A denied write never reaches the memory write enable, and a denied read returns zero.

Software configures the block over a simple 32-bit register bus. Register reads are combinational and writes land on the clock edge. The first illegal access after the fault flags were last cleared is recorded: its cause, its page offset and its attributes. Software clears the flags with a write-one-to-clear register.

Top module: `fw_page_guard`

## Requirements
- R1: After reset every configuration register reads zero, and a non-secure access by any compartment to any page is granted. The page index is address bits 16:12 of the offset into the protected area.
- R2: When the control bit is clear, an access whose secure flag differs from the page attribute is denied. A page is secure when any bit of its 8-bit field at 0x100 + 4×page is set.
- R3: With control register 0x00 bit 31 set, a secure access to a non-secure page is granted, while a non-secure access to a secure page is still denied.
- R4: With filtering disabled for a page, an unprivileged access is denied when that page is privileged, that is, when any bit of its 8-bit field at 0x200 + 4×page is set. A privileged access to it is granted.
- R5: With filtering enabled (bit 0 of 0xA00 + 4×page), a read by compartment x needs bit page of the read bitmap at 0x808 + 0x20×x, and a write needs the same bit of the write bitmap at 0x810 + 0x20×x.
- R6: With filtering enabled, an unprivileged access is denied when bit page of compartment x's privilege bitmap at 0x800 + 0x20×x is set. The default privilege field of the page is then ignored.
- R7: With filtering enabled, an access carrying compartment ID 7, which has no bitmaps, is denied.
- R8: The grant output is combinational. The memory write enable is high only for a granted write, and read data is forwarded only for a granted read and is zero otherwise.
- R9: The first denial sets the status register at 0x08: bit 1 for a security or default-privilege denial, bit 0 for a compartment-rule denial. It also loads the 17-bit offset at 0x24 and the attributes at 0x20 (bit 0 write, bit 1 secure, bit 2 privileged, bits 6:4 compartment ID).
- R10: While any status flag is set, further denials are not recorded. Writing 1 to bit 0 or bit 1 of 0x0C clears the matching flag.
- R11: The security and privilege fields read back as 8 bits. The filter register keeps bits 0, 2 and 6:4 only. Bitmaps are 32 bits wide. Unmapped addresses read zero.
- R12: A configuration write changes decisions only from the following cycle. An access in the same cycle as the write is judged on the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | Access request present |
| accAddr | input | 17 | Offset into the protected area |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSecure | input | 1 | Access is secure |
| accPriv | input | 1 | Access is privileged |
| accCid | input | 3 | Compartment ID of the requester |
| accGrant | output | 1 | Access allowed (same cycle) |
| memWe | output | 1 | Write enable toward memory |
| memRdata | input | 32 | Read data from memory |
| accRdata | output | 32 | Read data returned to the requester |
| regAddr | input | 12 | Register byte address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |

## Verification
The assertions assume that the access attributes and register bus inputs are stable around each rising edge. They also assume that the memory read data belongs to the address presented in the same cycle. The bench drives every input on the falling edge and holds it for a full cycle, so each request, and each register write that shares a cycle with a request, is seen once and whole. Compartment ID 7 is driven on purpose to probe the unsupported-ID path. Addresses always stay inside the 17-bit area, so no page index goes out of range.

// File: rtl/fw_pkg.sv
package fw_pkg;
  // strobes from the decision logic to the register datapath
  typedef struct packed {
    logic capture;   // record this denial
    logic cidClass;  // 1: compartment rule, 0: security/privilege attribute
  } faultStb_t;

  localparam int REG_CTRL   = 12'h000;
  localparam int REG_STATUS = 12'h008;
  localparam int REG_CLEAR  = 12'h00C;
  localparam int REG_INFO   = 12'h020;
  localparam int REG_FADDR  = 12'h024;
  localparam int REG_SEC    = 12'h100;
  localparam int REG_PRIV   = 12'h200;
  localparam int REG_CPRIV  = 12'h800;
  localparam int REG_CRD    = 12'h808;
  localparam int REG_CWR    = 12'h810;
  localparam int REG_FILT   = 12'hA00;
  localparam int CID_STRIDE = 12'h020;
endpackage

// File: rtl/fw_check.sv
module fw_check
  import fw_pkg::*;
#(
  parameter int PAGES      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int CIDS       = 7,
  parameter int CID_W      = 3,
  localparam int PG_W      = $clog2(PAGES),
  localparam int ADDR_W    = PAGE_SHIFT + PG_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        accValid,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic                        accWrite,
  input  logic                        accSecure,
  input  logic                        accPriv,
  input  logic [CID_W-1:0]            accCid,
  input  logic [PAGES-1:0]            secPage,
  input  logic [PAGES-1:0]            privPage,
  input  logic [PAGES-1:0]            filtEn,
  input  logic [CIDS-1:0][PAGES-1:0]  rdMap,
  input  logic [CIDS-1:0][PAGES-1:0]  wrMap,
  input  logic [CIDS-1:0][PAGES-1:0]  pvMap,
  input  logic                        secToNs,
  input  logic                        noFault,
  output logic                        grant,
  output faultStb_t                   stb
);
  logic [PG_W-1:0] page;
  logic cidOk, rdBit, wrBit, pvBit;
  logic secOk, attrFail, cidFail;

  assign page = accAddr[ADDR_W-1:PAGE_SHIFT];

  always_comb begin
    cidOk = 1'b0;
    rdBit = 1'b0;
    wrBit = 1'b0;
    pvBit = 1'b0;
    for (int c = 0; c < CIDS; c++) begin
      if (accCid == CID_W'(c)) begin
        cidOk = 1'b1;
        rdBit = rdMap[c][page];
        wrBit = wrMap[c][page];
        pvBit = pvMap[c][page];
      end
    end
  end

  always_comb begin
    secOk    = (accSecure == secPage[page]) || (accSecure && secToNs);
    attrFail = !secOk || (!filtEn[page] && privPage[page] && !accPriv);
    cidFail  = filtEn[page] &&
               (!cidOk || (accWrite ? !wrBit : !rdBit) || (pvBit && !accPriv));
    grant    = accValid && !attrFail && !cidFail;
    stb.capture  = accValid && !grant && noFault;
    stb.cidClass = !attrFail;
  end

  // non-secure requester never reaches a secure page
  assert_ns_secure_denied_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accSecure && secPage[page]) |-> !grant);

  // unsupported compartment ID is refused on filtered pages
  assert_bad_cid_denied_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && filtEn[page] && (int'(accCid) >= CIDS)) |-> !grant);
endmodule

// File: rtl/fw_regs.sv
module fw_regs
  import fw_pkg::*;
#(
  parameter int PAGES      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int CIDS       = 7,
  parameter int CID_W      = 3,
  localparam int PG_W      = $clog2(PAGES),
  localparam int ADDR_W    = PAGE_SHIFT + PG_W,
  localparam int INFO_W    = 4 + CID_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [11:0]                 regAddr,
  input  logic                        regWe,
  input  logic [31:0]                 regWdata,
  output logic [31:0]                 regRdata,
  input  faultStb_t                   stb,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic                        accWrite,
  input  logic                        accSecure,
  input  logic                        accPriv,
  input  logic [CID_W-1:0]            accCid,
  output logic [PAGES-1:0]            secPage,
  output logic [PAGES-1:0]            privPage,
  output logic [PAGES-1:0]            filtEn,
  output logic [CIDS-1:0][PAGES-1:0]  rdMap,
  output logic [CIDS-1:0][PAGES-1:0]  wrMap,
  output logic [CIDS-1:0][PAGES-1:0]  pvMap,
  output logic                        secToNs,
  output logic                        noFault
);
  logic [PAGES-1:0][7:0]       secFld;
  logic [PAGES-1:0][7:0]       privFld;
  logic [PAGES-1:0][CID_W+1:0] filtFld;   // {delegated id, delegate en, filter en}
  logic [1:0]                  flags;
  logic [ADDR_W-1:0]           faultAddr;
  logic [INFO_W-1:0]           faultInfo;
  logic                        clrHit;

  assign clrHit  = regWe && (regAddr == 12'(REG_CLEAR));
  assign noFault = (flags == 2'b00);

  generate
    for (genvar p = 0; p < PAGES; p++) begin : g_page
      assign secPage[p]  = |secFld[p];
      assign privPage[p] = |privFld[p];
      assign filtEn[p]   = filtFld[p][0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secToNs <= 1'b0;
      secFld  <= '0;
      privFld <= '0;
      filtFld <= '0;
      rdMap   <= '0;
      wrMap   <= '0;
      pvMap   <= '0;
    end else if (regWe) begin
      if (regAddr == 12'(REG_CTRL)) secToNs <= regWdata[31];
      for (int p = 0; p < PAGES; p++) begin
        if (regAddr == 12'(REG_SEC + 4*p))  secFld[p]  <= regWdata[7:0];
        if (regAddr == 12'(REG_PRIV + 4*p)) privFld[p] <= regWdata[7:0];
        if (regAddr == 12'(REG_FILT + 4*p))
          filtFld[p] <= {regWdata[4+CID_W-1:4], regWdata[2], regWdata[0]};
      end
      for (int c = 0; c < CIDS; c++) begin
        if (regAddr == 12'(REG_CPRIV + CID_STRIDE*c)) pvMap[c] <= regWdata[PAGES-1:0];
        if (regAddr == 12'(REG_CRD + CID_STRIDE*c))   rdMap[c] <= regWdata[PAGES-1:0];
        if (regAddr == 12'(REG_CWR + CID_STRIDE*c))   wrMap[c] <= regWdata[PAGES-1:0];
      end
    end
  end

  // fault record: capture only from a clean state, clear is write-one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= 2'b00;
      faultAddr <= '0;
      faultInfo <= '0;
    end else if (stb.capture) begin
      flags     <= stb.cidClass ? 2'b01 : 2'b10;
      faultAddr <= accAddr;
      faultInfo <= {accCid, 1'b0, accPriv, accSecure, accWrite};
    end else if (clrHit) begin
      flags <= flags & ~regWdata[1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == 12'(REG_CTRL))   regRdata[31] = secToNs;
    if (regAddr == 12'(REG_STATUS)) regRdata[1:0] = flags;
    if (regAddr == 12'(REG_INFO))   regRdata[INFO_W-1:0] = faultInfo;
    if (regAddr == 12'(REG_FADDR))  regRdata[ADDR_W-1:0] = faultAddr;
    for (int p = 0; p < PAGES; p++) begin
      if (regAddr == 12'(REG_SEC + 4*p))  regRdata[7:0] = secFld[p];
      if (regAddr == 12'(REG_PRIV + 4*p)) regRdata[7:0] = privFld[p];
      if (regAddr == 12'(REG_FILT + 4*p)) begin
        regRdata[0]              = filtFld[p][0];
        regRdata[2]              = filtFld[p][1];
        regRdata[4+CID_W-1:4]    = filtFld[p][CID_W+1:2];
      end
    end
    for (int c = 0; c < CIDS; c++) begin
      if (regAddr == 12'(REG_CPRIV + CID_STRIDE*c)) regRdata[PAGES-1:0] = pvMap[c];
      if (regAddr == 12'(REG_CRD + CID_STRIDE*c))   regRdata[PAGES-1:0] = rdMap[c];
      if (regAddr == 12'(REG_CWR + CID_STRIDE*c))   regRdata[PAGES-1:0] = wrMap[c];
    end
  end

  // a single cause is ever recorded
  assert_single_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flags));

  // recorded fault is frozen until software clears it
  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!noFault && !clrHit) |=> ($stable(flags) && $stable(faultAddr) && $stable(faultInfo)));

  // clearing both bits empties the status
  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && (regWdata[1:0] == 2'b11) && !noFault) |=> (flags == 2'b00));
endmodule

// File: rtl/fw_page_guard.sv
module fw_page_guard
  import fw_pkg::*;
#(
  parameter int PAGES      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int CIDS       = 7,
  parameter int CID_W      = 3,
  localparam int ADDR_W    = PAGE_SHIFT + $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSecure,
  input  logic              accPriv,
  input  logic [CID_W-1:0]  accCid,
  output logic              accGrant,
  output logic              memWe,
  input  logic [31:0]       memRdata,
  output logic [31:0]       accRdata,
  input  logic [11:0]       regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata
);
  logic [PAGES-1:0]           secPage, privPage, filtEn;
  logic [CIDS-1:0][PAGES-1:0] rdMap, wrMap, pvMap;
  logic                       secToNs, noFault;
  faultStb_t                  stb;

  fw_check #(.PAGES(PAGES), .PAGE_SHIFT(PAGE_SHIFT), .CIDS(CIDS), .CID_W(CID_W)) u_check (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .accSecure(accSecure), .accPriv(accPriv), .accCid(accCid),
    .secPage(secPage), .privPage(privPage), .filtEn(filtEn),
    .rdMap(rdMap), .wrMap(wrMap), .pvMap(pvMap),
    .secToNs(secToNs), .noFault(noFault),
    .grant(accGrant), .stb(stb)
  );

  fw_regs #(.PAGES(PAGES), .PAGE_SHIFT(PAGE_SHIFT), .CIDS(CIDS), .CID_W(CID_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .stb(stb),
    .accAddr(accAddr), .accWrite(accWrite), .accSecure(accSecure),
    .accPriv(accPriv), .accCid(accCid),
    .secPage(secPage), .privPage(privPage), .filtEn(filtEn),
    .rdMap(rdMap), .wrMap(wrMap), .pvMap(pvMap),
    .secToNs(secToNs), .noFault(noFault)
  );

  assign memWe    = accValid && accWrite && accGrant;
  assign accRdata = (accValid && !accWrite && accGrant) ? memRdata : 32'h0;
endmodule

// File: tb/fw_page_guard_test.sv
module fw_page_guard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, accSecure = 1'b0, accPriv = 1'b0;
  logic [16:0] accAddr = '0;
  logic [2:0]  accCid = '0;
  logic        accGrant, memWe;
  logic [31:0] memRdata, accRdata, regRdata;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  bit          mCtrl;
  int          mSec[32], mPriv[32], mFilt[32];
  logic [31:0] mRd[7], mWr[7], mPv[7];
  int          mFlags, mInfo, mAddr;

  always #4 clk = ~clk;
  assign memRdata = 32'hC0DE_0000 | 32'(accAddr);

  fw_page_guard uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .accSecure(accSecure), .accPriv(accPriv), .accCid(accCid),
    .accGrant(accGrant), .memWe(memWe), .memRdata(memRdata), .accRdata(accRdata),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [31:0] mRead(int a);
    if (a == 'h000) return {mCtrl, 31'b0};
    if (a == 'h008) return 32'(mFlags);
    if (a == 'h020) return 32'(mInfo);
    if (a == 'h024) return 32'(mAddr);
    if (a >= 'h100 && a < 'h180 && a % 4 == 0) return 32'(mSec[(a - 'h100) / 4]);
    if (a >= 'h200 && a < 'h280 && a % 4 == 0) return 32'(mPriv[(a - 'h200) / 4]);
    if (a >= 'hA00 && a < 'hA80 && a % 4 == 0) return 32'(mFilt[(a - 'hA00) / 4]);
    for (int x = 0; x < 7; x++) begin
      if (a == 'h800 + 'h20 * x) return mPv[x];
      if (a == 'h808 + 'h20 * x) return mRd[x];
      if (a == 'h810 + 'h20 * x) return mWr[x];
    end
    return 0;
  endfunction

  function automatic void mWrite(int a, logic [31:0] d);
    if (a == 'h000) mCtrl = d[31];
    if (a >= 'h100 && a < 'h180 && a % 4 == 0) mSec[(a - 'h100) / 4] = int'(d & 32'hFF);
    if (a >= 'h200 && a < 'h280 && a % 4 == 0) mPriv[(a - 'h200) / 4] = int'(d & 32'hFF);
    if (a >= 'hA00 && a < 'hA80 && a % 4 == 0) mFilt[(a - 'hA00) / 4] = int'(d & 32'h75);
    for (int x = 0; x < 7; x++) begin
      if (a == 'h800 + 'h20 * x) mPv[x] = d;
      if (a == 'h808 + 'h20 * x) mRd[x] = d;
      if (a == 'h810 + 'h20 * x) mWr[x] = d;
    end
  endfunction

  function automatic bit mGrant(int addr, bit wr, bit sec, bit pv, int cid, output bit attrBad);
    int pg = addr / 4096;
    bit pSec = mSec[pg] != 0;
    bit secOk = (sec == pSec) || (sec && mCtrl);
    bit filt = mFilt[pg][0];
    bit cidBad;
    attrBad = !secOk || (!filt && mPriv[pg] != 0 && !pv);
    if (!filt) cidBad = 0;
    else if (cid >= 7) cidBad = 1;
    else cidBad = (wr ? !mWr[cid][pg] : !mRd[cid][pg]) || (mPv[cid][pg] && !pv);
    return !attrBad && !cidBad;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare all outputs to the model, then advance the model
  task automatic step(string tag, bit v, int addr, bit wr, bit sec, bit pv, int cid,
                      bit rwe, int raddr, logic [31:0] rdat);
    bit g, attrBad;
    logic [31:0] eRd;
    @(negedge clk);
    accValid = v; accAddr = 17'(addr); accWrite = wr; accSecure = sec;
    accPriv = pv; accCid = 3'(cid);
    regWe = rwe; regAddr = 12'(raddr); regWdata = rdat;
    #1;
    g = v && mGrant(addr, wr, sec, pv, cid, attrBad);
    eRd = (v && !wr && g) ? (32'hC0DE_0000 | 32'(addr)) : 32'h0;
    chk(accGrant == g, tag, "grant", 32'(accGrant), 32'(g));
    chk(memWe == (v && wr && g), tag, "memWe", 32'(memWe), 32'(v && wr && g));
    chk(accRdata == eRd, tag, "rdata", accRdata, eRd);
    chk(regRdata == mRead(raddr), tag, "regRdata", regRdata, mRead(raddr));
    @(posedge clk);
    if (v && !g && mFlags == 0) begin
      mFlags = attrBad ? 2 : 1;
      mAddr  = addr;
      mInfo  = (cid << 4) | (int'(pv) << 2) | (int'(sec) << 1) | int'(wr);
    end else if (rwe && raddr == 'h00C) begin
      mFlags = mFlags & ~int'(rdat[1:0]);
    end
    if (rwe) mWrite(raddr, rdat);
  endtask

  task automatic rd(string tag, int a);
    step(tag, 0, 0, 0, 0, 0, 0, 0, a, 0);
  endtask
  task automatic wrReg(string tag, int a, logic [31:0] d);
    step(tag, 0, 0, 0, 0, 0, 0, 1, a, d);
  endtask
  task automatic acc(string tag, int addr, bit wr, bit sec, bit pv, int cid);
    step(tag, 1, addr, wr, sec, pv, cid, 0, 'h008, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mCtrl = 0; mFlags = 0; mInfo = 0; mAddr = 0;
    for (int i = 0; i < 32; i++) begin mSec[i] = 0; mPriv[i] = 0; mFilt[i] = 0; end
    for (int i = 0; i < 7; i++) begin mRd[i] = 0; mWr[i] = 0; mPv[i] = 0; end
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1 / R11: reset values
    rd("R1", 'h000); rd("R1", 'h108); rd("R1", 'h204); rd("R1", 'hA0C);
    rd("R1", 'h868); rd("R1", 'h8D0); rd("R1", 'h008);
    acc("R1", 'h3010, 0, 0, 0, 5);
    acc("R1", 'h1F004, 1, 0, 1, 6);

    // R2: secure access to non-secure page, first fault captured
    acc("R2", 'h3020, 0, 1, 0, 2);
    rd("R9", 'h008); rd("R9", 'h024); rd("R9", 'h020);
    // R10: second violation not recorded, partial and full clear
    acc("R10", 'h6100, 1, 1, 1, 4);
    rd("R10", 'h024); rd("R10", 'h020);
    wrReg("R10", 'h00C, 32'h1); rd("R10", 'h008);
    wrReg("R10", 'h00C, 32'h2); rd("R10", 'h008);

    // R12: access in the write cycle uses old control, then R3
    step("R12", 1, 'h3000, 0, 1, 0, 1, 1, 'h000, 32'h8000_0000);
    acc("R3", 'h3000, 0, 1, 0, 1);
    rd("R3", 'h000);
    wrReg("R3", 'h00C, 32'h3);
    wrReg("R3", 'h110, 32'hFF);
    acc("R3", 'h4000, 0, 0, 0, 0);
    acc("R3", 'h4008, 1, 1, 0, 0);
    wrReg("R2", 'h000, 32'h0); wrReg("R2", 'h00C, 32'h3);
    acc("R2", 'h4000, 1, 0, 1, 0);
    acc("R2", 'h4000, 1, 1, 1, 0);
    wrReg("R2", 'h00C, 32'h3);

    // R4: default privilege, filtering off
    wrReg("R4", 'h21C, 32'hFF);
    acc("R4", 'h7000, 0, 0, 0, 3);
    acc("R4", 'h7004, 1, 0, 1, 3);
    wrReg("R4", 'h00C, 32'h3);

    // R5/R6/R7: compartment filtering on page 7
    wrReg("R5", 'hA1C, 32'h1);
    acc("R6", 'h7000, 0, 0, 1, 2);
    rd("R9", 'h008); rd("R9", 'h020);
    wrReg("R5", 'h00C, 32'h1);
    wrReg("R5", 'h848, 32'h0000_0080);
    acc("R5", 'h7040, 0, 0, 0, 2);
    acc("R5", 'h7040, 1, 0, 0, 2);
    wrReg("R5", 'h850, 32'h0000_0080);
    acc("R8", 'h7044, 1, 0, 0, 2);
    acc("R5", 'h7044, 0, 0, 0, 1);
    wrReg("R6", 'h840, 32'h0000_0080);
    acc("R6", 'h7048, 0, 0, 0, 2);
    acc("R6", 'h7048, 0, 0, 1, 2);
    acc("R7", 'h7048, 0, 0, 1, 7);
    rd("R10", 'h008);

    // R11: field widths and unmapped space
    wrReg("R11", 'hA20, 32'hFFFF_FFFF); rd("R11", 'hA20);
    wrReg("R11", 'h17C, 32'hFFFF_FFFF); rd("R11", 'h17C);
    wrReg("R11", 'h8C8, 32'hDEAD_BEEF); rd("R11", 'h8C8);
    rd("R11", 'h0FC); rd("R11", 'h8E0); rd("R11", 'h00C);

    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule